// File: doc/BRIEF.md
# Masked-Write GPIO Output Register Block

This block stores the output value and the output-enable value of a general-purpose I/O port. The pad logic takes both vectors from it, and software reaches both through a simple register port. Each vector can be changed in two ways. A direct write replaces the whole word. A masked half-word write changes only selected bits.

A masked write goes to one of four alias offsets. Each alias covers one half of one vector. In the written word, the upper half is a per-bit mask and the lower half holds the new values. Only bits whose mask bit is set change, and they change in a single write. Software therefore never has to do a read-modify-write and cannot race another writer on the bits it does not touch.

The block also provides a registered copy of the pin levels for software to read. Pad tri-state control, interrupts and bus protocol conversion are handled outside this block.

Top module: `gpioOutRegs`

## Requirements
- R1: After reset, the output value, the output-enable value and their direct read-backs (offsets 0x14 and 0x20) are all zero, so every pin starts as an input.
- R2: A write to offset 0x14 replaces all 32 output value bits on the next clock edge. A read of 0x14 returns the full current output value.
- R3: A write to offset 0x20 replaces all 32 output-enable bits on the next clock edge. A read of 0x20 returns the full current enable value. A 1 in an enable bit marks that pin as driven.
- R4: A write to offset 0x18 sets output bit i (0..15) to written bit i only where written bit 16+i is 1. Output bits 31:16 keep their values.
- R5: A write to offset 0x1c sets output bit 16+i to written bit i only where written bit 16+i is 1. Output bits 15:0 keep their values.
- R6: Writes to offsets 0x24 and 0x28 apply the same masked scheme to output-enable bits 15:0 and 31:16 respectively.
- R7: A masked write whose mask half is all zero changes neither vector.
- R8: A read of any masked alias (0x18, 0x1c, 0x24, 0x28) returns zero in bits 31:16 and the current 16 bits of its half in bits 15:0.
- R9: A read of offset 0x10 returns the pin input levels captured at the previous clock edge. A write to 0x10 changes neither vector.
- R10: A write to an unmapped offset changes neither vector, and a read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pinIn | input | 32 | Pin input levels |
| dataOut | output | 32 | Output value toward the pads |
| oeOut | output | 32 | Output enable toward the pads, 1 = drive |

## Verification
The hardest case to reach is a masked write that changes some bits and leaves others alone within the same half, on a vector that already holds a mixed, non-trivial value. To set this up, the stimulus first loads both vectors with direct writes using patterns that are not symmetric. It then sends masks that cover only part of a half, so every bit in the half falls into one of four groups: set, cleared, kept high or kept low. Each half of each vector is checked both at the pad outputs and through its alias read-back. Writes with an all-zero mask, writes to the input offset and writes to unmapped offsets are then applied, and the test confirms that neither vector moved.

// File: rtl/gpioOutPkg.sv
package gpioOutPkg;

  localparam int unsigned OFF_PIN_IN  = 32'h10;
  localparam int unsigned OFF_DATA    = 32'h14;
  localparam int unsigned OFF_DATA_LO = 32'h18;
  localparam int unsigned OFF_DATA_HI = 32'h1c;
  localparam int unsigned OFF_OE      = 32'h20;
  localparam int unsigned OFF_OE_LO   = 32'h24;
  localparam int unsigned OFF_OE_HI   = 32'h28;

  localparam int unsigned NUM_HALVES = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PIN,
    RD_DATA,
    RD_OE,
    RD_DATA_LO,
    RD_DATA_HI,
    RD_OE_LO,
    RD_OE_HI
  } rdSelT;

  typedef struct packed {
    logic                  dataFull;
    logic [NUM_HALVES-1:0] dataHalf;
    logic                  oeFull;
    logic [NUM_HALVES-1:0] oeHalf;
    rdSelT                 rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/gpioOutCtrl.sv
module gpioOutCtrl
  import gpioOutPkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobeT        strobe
);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    if (addr == ADDR_W'(OFF_PIN_IN)) begin
      strobe.rdSel = RD_PIN;           // R9: read only, writes ignored
    end else if (addr == ADDR_W'(OFF_DATA)) begin
      strobe.rdSel    = RD_DATA;
      strobe.dataFull = wrEn;          // R2
    end else if (addr == ADDR_W'(OFF_DATA_LO)) begin
      strobe.rdSel       = RD_DATA_LO;
      strobe.dataHalf[0] = wrEn;       // R4
    end else if (addr == ADDR_W'(OFF_DATA_HI)) begin
      strobe.rdSel       = RD_DATA_HI;
      strobe.dataHalf[1] = wrEn;       // R5
    end else if (addr == ADDR_W'(OFF_OE)) begin
      strobe.rdSel  = RD_OE;
      strobe.oeFull = wrEn;            // R3
    end else if (addr == ADDR_W'(OFF_OE_LO)) begin
      strobe.rdSel     = RD_OE_LO;
      strobe.oeHalf[0] = wrEn;         // R6
    end else if (addr == ADDR_W'(OFF_OE_HI)) begin
      strobe.rdSel     = RD_OE_HI;
      strobe.oeHalf[1] = wrEn;         // R6
    end
  end

endmodule

// File: rtl/gpioOutDatapath.sv
module gpioOutDatapath
  import gpioOutPkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] oeOut,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned HALF = DATA_W / NUM_HALVES;

  logic [DATA_W-1:0] dataQ, dataD;
  logic [DATA_W-1:0] oeQ, oeD;
  logic [DATA_W-1:0] pinQ;
  logic [HALF-1:0]   wrMask, wrVal;

  assign wrVal  = wdata[HALF-1:0];
  assign wrMask = wdata[DATA_W-1:HALF];

  function automatic logic [HALF-1:0] mergeHalf(
    input logic [HALF-1:0] cur,
    input logic [HALF-1:0] val,
    input logic [HALF-1:0] msk
  );
    return (val & msk) | (cur & ~msk);   // R7: zero mask keeps cur
  endfunction

  always_comb begin
    dataD = dataQ;
    oeD   = oeQ;
    if (strobe.dataFull) dataD = wdata;
    if (strobe.oeFull)   oeD   = wdata;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (strobe.dataHalf[h])
        dataD[h*HALF +: HALF] = mergeHalf(dataQ[h*HALF +: HALF], wrVal, wrMask);
      if (strobe.oeHalf[h])
        oeD[h*HALF +: HALF] = mergeHalf(oeQ[h*HALF +: HALF], wrVal, wrMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;                     // R1
      oeQ   <= '0;
      pinQ  <= '0;
    end else begin
      dataQ <= dataD;
      oeQ   <= oeD;
      pinQ  <= pinIn;                  // R9
    end
  end

  always_comb begin
    rdata = '0;                        // R10: unmapped reads zero
    unique case (strobe.rdSel)
      RD_PIN:     rdata = pinQ;
      RD_DATA:    rdata = dataQ;
      RD_OE:      rdata = oeQ;
      RD_DATA_LO: rdata = {{HALF{1'b0}}, dataQ[HALF-1:0]};       // R8
      RD_DATA_HI: rdata = {{HALF{1'b0}}, dataQ[DATA_W-1:HALF]};
      RD_OE_LO:   rdata = {{HALF{1'b0}}, oeQ[HALF-1:0]};
      RD_OE_HI:   rdata = {{HALF{1'b0}}, oeQ[DATA_W-1:HALF]};
      default:    rdata = '0;
    endcase
  end

  assign dataOut = dataQ;
  assign oeOut   = oeQ;

endmodule

// File: rtl/gpioOutRegs.sv
module gpioOutRegs
  import gpioOutPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] oeOut
);

  ctrlStrobeT strobe;

  gpioOutCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpioOutDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdata   (wdata),
    .pinIn   (pinIn),
    .dataOut (dataOut),
    .oeOut   (oeOut),
    .rdata   (rdata)
  );

endmodule

// File: rtl/gpioOutRegsChk.sv
module gpioOutRegsChk
  import gpioOutPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] pinIn,
  input logic [DATA_W-1:0] dataOut,
  input logic [DATA_W-1:0] oeOut
);

  localparam int unsigned HALF = DATA_W / 2;

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dataOut == '0 && oeOut == '0));

  p_direct_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_DATA)) |=> dataOut == $past(wdata));

  p_direct_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_OE)) |=> oeOut == $past(wdata));

  p_mask_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_DATA_LO)) |=>
      (dataOut[HALF-1:0] == (($past(wdata[HALF-1:0]) & $past(wdata[DATA_W-1:HALF])) |
                             ($past(dataOut[HALF-1:0]) & ~$past(wdata[DATA_W-1:HALF])))) &&
      $stable(dataOut[DATA_W-1:HALF]) && $stable(oeOut));

  p_mask_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_DATA_HI)) |=>
      (dataOut[DATA_W-1:HALF] == (($past(wdata[HALF-1:0]) & $past(wdata[DATA_W-1:HALF])) |
                                  ($past(dataOut[DATA_W-1:HALF]) & ~$past(wdata[DATA_W-1:HALF])))) &&
      $stable(dataOut[HALF-1:0]) && $stable(oeOut));

  p_mask_oe_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_W'(OFF_OE_LO) || addr == ADDR_W'(OFF_OE_HI))) |=> $stable(dataOut));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(dataOut) && $stable(oeOut)));

  p_alias_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(OFF_DATA_LO)) |-> rdata == {{HALF{1'b0}}, dataOut[HALF-1:0]});

  p_pin_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && addr == ADDR_W'(OFF_PIN_IN)) |-> rdata == $past(pinIn));

endmodule

bind gpioOutRegs gpioOutRegsChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_gpioOutRegs.sv
`timescale 1ns/1ps
module tb_gpioOutRegs;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] pinIn;
  logic [31:0] dataOut;
  logic [31:0] oeOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expData = '0;
  logic [31:0] expOe   = '0;

  always #2.5 clk = ~clk;

  gpioOutRegs dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pinIn(pinIn), .dataOut(dataOut), .oeOut(oeOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] merge16(input logic [15:0] cur, input logic [31:0] w);
    return (w[15:0] & w[31:16]) | (cur & ~w[31:16]);
  endfunction

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 8'hff; wdata = '0;
  endtask

  task automatic readCheck(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
    addr = 8'hff;
  endtask

  task automatic checkOutputs(input string tag);
    check({tag, " dataOut"}, dataOut, expData);
    check({tag, " oeOut"},   oeOut,   expOe);
  endtask

  task automatic testReset();
    checkOutputs("R1 reset");
    readCheck("R1 read data", 8'h14, 32'h0);
    readCheck("R1 read oe",   8'h20, 32'h0);
  endtask

  task automatic testDirect();
    writeReg(8'h14, 32'hA5A5_3C3C); expData = 32'hA5A5_3C3C;
    check("R2 direct data", dataOut, expData);
    readCheck("R2 read data", 8'h14, expData);
    writeReg(8'h20, 32'hF0F0_0F0F); expOe = 32'hF0F0_0F0F;
    check("R3 direct oe", oeOut, expOe);
    readCheck("R3 read oe", 8'h20, expOe);
    check("R3 data untouched", dataOut, expData);
  endtask

  task automatic testMaskData();
    writeReg(8'h18, 32'h00FF_1234);
    expData[15:0] = merge16(expData[15:0], 32'h00FF_1234);
    checkOutputs("R4 mask lo");
    check("R4 value", dataOut, 32'hA5A5_3C34);
    readCheck("R8 read data lo", 8'h18, {16'h0, expData[15:0]});
    writeReg(8'h1c, 32'hFF00_5678);
    expData[31:16] = merge16(expData[31:16], 32'hFF00_5678);
    checkOutputs("R5 mask hi");
    check("R5 value", dataOut, 32'h56A5_3C34);
    readCheck("R8 read data hi", 8'h1c, {16'h0, expData[31:16]});
  endtask

  task automatic testMaskOe();
    writeReg(8'h24, 32'hFFFF_BEEF);
    expOe[15:0] = merge16(expOe[15:0], 32'hFFFF_BEEF);
    checkOutputs("R6 oe lo");
    writeReg(8'h28, 32'h000F_1234);
    expOe[31:16] = merge16(expOe[31:16], 32'h000F_1234);
    checkOutputs("R6 oe hi");
    check("R6 value", oeOut, 32'hF0F4_BEEF);
    readCheck("R8 read oe lo", 8'h24, {16'h0, expOe[15:0]});
    readCheck("R8 read oe hi", 8'h28, {16'h0, expOe[31:16]});
  endtask

  task automatic testZeroMask();
    writeReg(8'h18, 32'h0000_FFFF);
    writeReg(8'h1c, 32'h0000_0000);
    writeReg(8'h24, 32'h0000_0000);
    writeReg(8'h28, 32'h0000_FFFF);
    checkOutputs("R7 zero mask");
  endtask

  task automatic testPinIn();
    @(negedge clk);
    pinIn = 32'hCAFE_F00D;
    @(negedge clk);
    readCheck("R9 pin read", 8'h10, 32'hCAFE_F00D);
    writeReg(8'h10, 32'h1234_5678);
    checkOutputs("R9 write ignored");
    readCheck("R9 pin after write", 8'h10, 32'hCAFE_F00D);
  endtask

  task automatic testUnmapped();
    writeReg(8'h40, 32'hFFFF_FFFF);
    writeReg(8'h0c, 32'hFFFF_FFFF);
    checkOutputs("R10 unmapped write");
    readCheck("R10 unmapped read", 8'h40, 32'h0);
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = 8'hff; wdata = '0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDirect();
    testMaskData();
    testMaskOe();
    testZeroMask();
    testPinIn();
    testUnmapped();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule